// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical page number after a translation cache miss. It reads a first-level (directory) entry and, unless that entry maps a large page, a second-level (table) entry. At each level it checks presence and permission. It then writes back any accessed and dirty flags that need setting, and reports either a physical page number or a fault record.

A single request is taken when `req_ready_o` is high. The root table's physical page number is captured with the request. Memory is reached through a port that carries one word transaction at a time: the block holds `mem_req_o`, together with the address, direction and write data, until `mem_ack_i` is high at a clock edge. Read data is taken on that same edge.

The virtual address is divided as follows: bits [31:22] index the directory, bits [21:12] index the table, and bits [11:0] are the page offset. Each entry is 4 bytes, and entry bits [31:12] give a 4 KB-aligned physical frame. The entry flag bits are: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, and bit 7 large page (directory level only).

Top module: `ptw_walker`

## Requirements
- R1: Out of reset, and between walks, `req_ready_o` is 1, `mem_req_o` is 0, and `done_o` and `fault_o` are 0.
- R2: The directory read goes to address {root_ppn, va[31:22], 2'b00}. When the walk needs a second level, the table read goes to {dir[31:12], va[21:12], 2'b00}. Both reads have `mem_we_o`=0.
- R3: A successful 4 KB walk pulses `done_o` for exactly one cycle, with `done_ppn_o` = table entry bits [31:12]. `done_o` and `fault_o` are never high together.
- R4: A present directory entry with bit 7 set ends the walk without a table read. `done_ppn_o` is then {dir[31:22], va[21:12]}.
- R5: If bit 0 is clear at the level being checked, the walk ends with a one-cycle `fault_o`, `fault_prot_o`=0, and no memory write.
- R6: At any level consulted, a write with bit 1 clear, or a user access with bit 2 clear, ends the walk with `fault_o` and `fault_prot_o`=1, and no memory write. The directory is checked before the table.
- R7: The fault record gives the request's virtual address on `fault_vaddr_o`, its direction on `fault_write_o` (1 = write) and its mode on `fault_user_o` (1 = user).
- R8: On success, bit 5 is set in every entry consulted. An entry is written back only if its bit 5 was clear, or it needs bit 6. The directory write comes before the leaf write.
- R9: On a successful write access, bit 6 of the leaf entry is set. If no flag changes, the walk makes no memory write.
- R10: Each memory request keeps its address, direction and data stable until acknowledged. `done_o` or `fault_o` rises only after the last acknowledged transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access |
| req_user_i | input | 1 | 1 = user mode access |
| root_ppn_i | input | 20 | Physical page number of the directory |
| req_ready_o | output | 1 | Walker idle, request accepted |
| mem_req_o | output | 1 | Memory transaction pending |
| mem_we_o | output | 1 | 1 = write transaction |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Updated entry for writes |
| mem_ack_i | input | 1 | Transaction completes at this edge |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| done_o | output | 1 | Successful translation pulse |
| done_ppn_o | output | 20 | Resulting physical page number |
| fault_o | output | 1 | Fault pulse |
| fault_vaddr_o | output | 32 | Faulting virtual address |
| fault_prot_o | output | 1 | 1 = protection, 0 = not present |
| fault_write_o | output | 1 | Faulting access was a write |
| fault_user_o | output | 1 | Faulting access was in user mode |

## Verification
The stability property assumes that the memory side never takes back a transaction: acknowledgement arrives only while `mem_req_o` is high, and the response model raises it for a single cycle after a random wait of zero to two cycles. The dirty-flag and accessed-flag properties assume that the directory frame and the table frames never overlap. The stimulus keeps to this by placing the root at frame 0x10 and drawing table frames only from 0x20 to 0x2F. Requests are raised only while `req_ready_o` is high and are dropped once accepted, so the walker never sees a request mid-walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int IDX_W     = 10;
  localparam int OFF_W     = 12;
  localparam int ENTRY_W   = 32;
  localparam int PPN_W     = VA_W - OFF_W;
  localparam int ENT_LOG   = 2;
  localparam int LEVELS    = 2;

  localparam int B_PRESENT  = 0;
  localparam int B_WRITABLE = 1;
  localparam int B_USER     = 2;
  localparam int B_ACCESSED = 5;
  localparam int B_DIRTY    = 6;
  localparam int B_LARGE    = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_DIR, ST_CHK_DIR, ST_RD_TBL, ST_CHK_TBL,
    ST_WB_DIR, ST_WB_LEAF, ST_DONE, ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter bit DIR_LEVEL = 1'b0
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               write_i,
  input  logic               user_i,
  output logic               present_o,
  output logic               perm_ok_o,
  output logic               leaf_o,
  output logic               need_wb_o,
  output logic [ENTRY_W-1:0] upd_o
);
  always_comb begin
    present_o = entry_i[B_PRESENT];
    perm_ok_o = !(write_i && !entry_i[B_WRITABLE]) && !(user_i && !entry_i[B_USER]);
    leaf_o    = DIR_LEVEL ? entry_i[B_LARGE] : 1'b1;
    upd_o     = entry_i;
    upd_o[B_ACCESSED] = 1'b1;
    if (leaf_o && write_i) upd_o[B_DIRTY] = 1'b1;
    need_wb_o = (upd_o != entry_i);
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0]   root_ppn_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic [ENTRY_W-1:0] dir_entry_i,
  output logic [VA_W-1:0]    dir_addr_o,
  output logic [VA_W-1:0]    tbl_addr_o,
  output logic [PPN_W-1:0]   large_ppn_o
);
  localparam int FRAME_W = ENTRY_W - OFF_W;
  localparam int LARGE_W = PPN_W - IDX_W;

  always_comb begin
    dir_addr_o  = {root_ppn_i, va_i[VA_W-1 -: IDX_W], {ENT_LOG{1'b0}}};
    tbl_addr_o  = {dir_entry_i[ENTRY_W-1 -: FRAME_W], va_i[OFF_W +: IDX_W], {ENT_LOG{1'b0}}};
    large_ppn_o = {dir_entry_i[ENTRY_W-1 -: LARGE_W], va_i[OFF_W +: IDX_W]};
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               req_write_i,
  input  logic               req_user_i,
  input  logic [PPN_W-1:0]   root_ppn_i,
  output logic               req_ready_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [VA_W-1:0]    mem_addr_o,
  output logic [ENTRY_W-1:0] mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               done_o,
  output logic [PPN_W-1:0]   done_ppn_o,
  output logic               fault_o,
  output logic [VA_W-1:0]    fault_vaddr_o,
  output logic               fault_prot_o,
  output logic               fault_write_o,
  output logic               fault_user_o
);
  walk_state_e state_q;
  logic [VA_W-1:0]    va_q, leaf_addr_q;
  logic [PPN_W-1:0]   root_q, ppn_q;
  logic [ENTRY_W-1:0] dir_q, tbl_q, leaf_upd_q;
  logic               wr_q, user_q, prot_q, leaf_wb_q;

  logic [VA_W-1:0]    dir_addr, tbl_addr;
  logic [PPN_W-1:0]   large_ppn;

  logic [ENTRY_W-1:0] entry_w [LEVELS];
  logic [ENTRY_W-1:0] upd_w   [LEVELS];
  logic               pres_w  [LEVELS];
  logic               perm_w  [LEVELS];
  logic               leaf_w  [LEVELS];
  logic               need_w  [LEVELS];

  assign entry_w[0] = dir_q;
  assign entry_w[1] = tbl_q;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
    ptw_entry_eval #(.DIR_LEVEL(lvl == 0)) u_eval (
      .entry_i   (entry_w[lvl]),
      .write_i   (wr_q),
      .user_i    (user_q),
      .present_o (pres_w[lvl]),
      .perm_ok_o (perm_w[lvl]),
      .leaf_o    (leaf_w[lvl]),
      .need_wb_o (need_w[lvl]),
      .upd_o     (upd_w[lvl])
    );
  end

  ptw_addr_gen u_addr (
    .root_ppn_i  (root_q),
    .va_i        (va_q),
    .dir_entry_i (dir_q),
    .dir_addr_o  (dir_addr),
    .tbl_addr_o  (tbl_addr),
    .large_ppn_o (large_ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      root_q      <= '0;
      wr_q        <= 1'b0;
      user_q      <= 1'b0;
      dir_q       <= '0;
      tbl_q       <= '0;
      ppn_q       <= '0;
      leaf_addr_q <= '0;
      leaf_upd_q  <= '0;
      leaf_wb_q   <= 1'b0;
      prot_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          wr_q    <= req_write_i;
          user_q  <= req_user_i;
          root_q  <= root_ppn_i;
          state_q <= ST_RD_DIR;
        end
        ST_RD_DIR: if (mem_ack_i) begin
          dir_q   <= mem_rdata_i;
          state_q <= ST_CHK_DIR;
        end
        ST_CHK_DIR: begin
          if (!pres_w[0]) begin
            prot_q  <= 1'b0;
            state_q <= ST_FAULT;
          end else if (!perm_w[0]) begin
            prot_q  <= 1'b1;
            state_q <= ST_FAULT;
          end else if (leaf_w[0]) begin
            ppn_q       <= large_ppn;
            leaf_addr_q <= dir_addr;
            leaf_upd_q  <= upd_w[0];
            leaf_wb_q   <= need_w[0];
            state_q     <= need_w[0] ? ST_WB_LEAF : ST_DONE;
          end else begin
            state_q <= ST_RD_TBL;
          end
        end
        ST_RD_TBL: if (mem_ack_i) begin
          tbl_q   <= mem_rdata_i;
          state_q <= ST_CHK_TBL;
        end
        ST_CHK_TBL: begin
          if (!pres_w[1]) begin
            prot_q  <= 1'b0;
            state_q <= ST_FAULT;
          end else if (!perm_w[1]) begin
            prot_q  <= 1'b1;
            state_q <= ST_FAULT;
          end else begin
            ppn_q       <= tbl_q[ENTRY_W-1 -: PPN_W];
            leaf_addr_q <= tbl_addr;
            leaf_upd_q  <= upd_w[1];
            leaf_wb_q   <= need_w[1];
            // directory accessed flag goes out first
            if (need_w[0])      state_q <= ST_WB_DIR;
            else if (need_w[1]) state_q <= ST_WB_LEAF;
            else                state_q <= ST_DONE;
          end
        end
        ST_WB_DIR: if (mem_ack_i) state_q <= leaf_wb_q ? ST_WB_LEAF : ST_DONE;
        ST_WB_LEAF: if (mem_ack_i) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = dir_addr;
    mem_wdata_o = upd_w[0];
    unique case (state_q)
      ST_RD_DIR: mem_req_o = 1'b1;
      ST_RD_TBL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = tbl_addr;
      end
      ST_WB_DIR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      ST_WB_LEAF: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = leaf_addr_q;
        mem_wdata_o = leaf_upd_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign fault_o       = (state_q == ST_FAULT);
  assign done_ppn_o    = ppn_q;
  assign fault_vaddr_o = va_q;
  assign fault_prot_o  = prot_q;
  assign fault_write_o = wr_q;
  assign fault_user_o  = user_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !done_o && !fault_o));

  p_result_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !$past(mem_we_o));

  p_wb_accessed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[B_ACCESSED]);

  p_leaf_dirty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB_LEAF && wr_q) |-> mem_wdata_o[B_DIRTY]);

  p_req_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] root_ppn = 20'h00010;
  logic        req_ready, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done, fault, fault_prot, fault_write, fault_user;
  logic [19:0] done_ppn;
  logic [31:0] fault_vaddr;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .req_user_i(req_user), .root_ppn_i(root_ppn), .req_ready_o(req_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .done_ppn_o(done_ppn), .fault_o(fault),
    .fault_vaddr_o(fault_vaddr), .fault_prot_o(fault_prot),
    .fault_write_o(fault_write), .fault_user_o(fault_user)
  );

  always #2.5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  logic        tr_we   [$];
  logic [31:0] tr_addr [$];
  logic [31:0] tr_data [$];
  int unsigned last_ack_cyc = 0;
  int unsigned wait_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        tr_we.push_back(mem_we);
        tr_addr.push_back(mem_addr);
        tr_data.push_back(mem_wdata);
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
        mem_ack = 1'b1;
        last_ack_cyc = cyc;
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end
  end

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected model
  bit          e_fault, e_prot;
  logic [19:0] e_ppn;
  logic        e_we   [$];
  logic [31:0] e_addr [$];
  logic [31:0] e_data [$];

  task automatic model(input logic [31:0] va, input bit w, input bit u);
    logic [31:0] da, d, ta, t, nd, nt;
    e_we.delete(); e_addr.delete(); e_data.delete();
    e_fault = 0; e_prot = 0; e_ppn = '0;
    da = {root_ppn, va[31:22], 2'b00};
    d = rd(da);
    e_we.push_back(0); e_addr.push_back(da); e_data.push_back(0);
    if (!d[0]) begin e_fault = 1; return; end
    if ((w && !d[1]) || (u && !d[2])) begin e_fault = 1; e_prot = 1; return; end
    if (d[7]) begin
      e_ppn = {d[31:22], va[21:12]};
      nd = d | 32'h20 | (w ? 32'h40 : 32'h0);
      if (nd != d) begin e_we.push_back(1); e_addr.push_back(da); e_data.push_back(nd); end
      return;
    end
    ta = {d[31:12], va[21:12], 2'b00};
    t = rd(ta);
    e_we.push_back(0); e_addr.push_back(ta); e_data.push_back(0);
    if (!t[0]) begin e_fault = 1; return; end
    if ((w && !t[1]) || (u && !t[2])) begin e_fault = 1; e_prot = 1; return; end
    e_ppn = t[31:12];
    if (!d[5]) begin e_we.push_back(1); e_addr.push_back(da); e_data.push_back(d | 32'h20); end
    nt = t | 32'h20 | (w ? 32'h40 : 32'h0);
    if (nt != t) begin e_we.push_back(1); e_addr.push_back(ta); e_data.push_back(nt); end
  endtask

  task automatic walk(input logic [31:0] va, input bit w, input bit u, input string tag);
    int guard;
    int unsigned end_cyc;
    model(va, w, u);
    tr_we.delete(); tr_addr.delete(); tr_data.delete();
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0; req_vaddr = $urandom; req_write = $urandom; req_user = $urandom;
    guard = 0;
    while (!(done || fault) && guard < 200) begin @(negedge clk); guard++; end
    end_cyc = cyc;
    check(fault == e_fault && done == !e_fault, {tag, " outcome"}, {30'b0, done, fault}, {30'b0, !e_fault, e_fault});
    if (e_fault) begin
      check(fault_prot == e_prot, {tag, " fault kind"}, {31'b0, fault_prot}, {31'b0, e_prot});
      check(fault_vaddr == va && fault_write == w && fault_user == u, "R7 fault record",
            fault_vaddr ^ {30'b0, fault_write, fault_user}, va ^ {30'b0, w, u});
    end else
      check(done_ppn == e_ppn, {tag, " ppn"}, {12'b0, done_ppn}, {12'b0, e_ppn});
    check(tr_we.size() == e_we.size(), "R2 R8 R9 transaction count", tr_we.size(), e_we.size());
    if (tr_we.size() == e_we.size())
      foreach (e_we[i])
        check(tr_we[i] == e_we[i] && tr_addr[i] == e_addr[i] && (!e_we[i] || tr_data[i] == e_data[i]),
              "R2 R8 R9 transaction", tr_addr[i] ^ (e_we[i] ? tr_data[i] : 0), e_addr[i] ^ e_data[i]);
    check(end_cyc > last_ack_cyc, "R10 result after last ack", end_cyc, last_ack_cyc + 1);
    @(negedge clk);
    check(req_ready && !done && !fault && !mem_req, "R1 idle after walk", {29'b0, req_ready, done, fault}, 32'h4);
  endtask

  function automatic logic [31:0] dir_a(input logic [9:0] i); return {root_ppn, i, 2'b00}; endfunction
  function automatic logic [31:0] tbl_a(input logic [19:0] f, input logic [9:0] i); return {f, i, 2'b00}; endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(req_ready && !mem_req && !done && !fault, "R1 in reset", {29'b0, req_ready, mem_req, done}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !mem_req && !done && !fault, "R1 after reset", {29'b0, req_ready, mem_req, done}, 32'h4);

    // 4 KB page, flags clear -> both entries written
    mem[dir_a(10'd1)] = {20'h00020, 12'h007};
    mem[tbl_a(20'h00020, 10'd2)] = {20'hABCDE, 12'h007};
    walk({10'd1, 10'd2, 12'h345}, 0, 1, "R3");
    check(rd(tbl_a(20'h00020, 10'd2)) == {20'hABCDE, 12'h027}, "R8 leaf accessed", rd(tbl_a(20'h00020, 10'd2)), {20'hABCDE, 12'h027});
    walk({10'd1, 10'd2, 12'h345}, 1, 0, "R9");
    check(rd(tbl_a(20'h00020, 10'd2)) == {20'hABCDE, 12'h067}, "R9 leaf dirty", rd(tbl_a(20'h00020, 10'd2)), {20'hABCDE, 12'h067});
    walk({10'd1, 10'd2, 12'h000}, 1, 1, "R9");   // nothing to update
    // large page
    mem[dir_a(10'd5)] = {10'h155, 10'h000, 12'h0A7};
    walk({10'd5, 10'h3C1, 12'h010}, 0, 1, "R4");
    walk({10'd5, 10'h001, 12'h010}, 1, 0, "R4");
    // not present at each level
    mem[dir_a(10'd9)] = 32'h0002_0006;
    walk({10'd9, 10'd0, 12'h0}, 0, 0, "R5");
    mem[dir_a(10'd3)] = {20'h00021, 12'h027};
    mem[tbl_a(20'h00021, 10'd7)] = {20'h12345, 12'h006};
    walk({10'd3, 10'd7, 12'h0}, 1, 1, "R5");
    // protection
    mem[tbl_a(20'h00021, 10'd8)] = {20'h12345, 12'h005};
    walk({10'd3, 10'd8, 12'h0}, 1, 0, "R6");
    mem[dir_a(10'd4)] = {20'h00022, 12'h003};
    walk({10'd4, 10'd8, 12'h0}, 0, 1, "R6");

    for (int n = 0; n < 400; n++) begin
      logic [9:0] di, ti;
      logic [19:0] fr;
      logic [31:0] d, t;
      di = $urandom; ti = $urandom;
      fr = 20'h00020 + ($urandom % 16);
      d = $urandom;
      d[0] = ($urandom % 8) != 0;
      d[7] = ($urandom % 4) == 0;
      if (!d[7]) d[31:12] = fr;
      t = $urandom;
      t[0] = ($urandom % 8) != 0;
      if (($urandom % 2) == 0) begin d[2:1] = 2'b11; t[2:1] = 2'b11; end
      mem[dir_a(di)] = d;
      mem[tbl_a(fr, ti)] = t;
      walk({di, ti, 12'($urandom)}, 1'($urandom), 1'($urandom), "R3 R4 R5 R6 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule